// File: doc/BRIEF.md
# Video Digitizer Register Target on a Two-Wire Bus

This block is a two-wire serial (I2C) target. It gives a host controller byte-wide access to the control and status registers of a video digitizer. It oversamples SCL and SDA on the system clock and recognises START, STOP and repeated START conditions. It runs single-byte register writes, and single-byte random reads that go through an internal index pointer. SDA is driven open-drain: the block only ever pulls the line low.

The block answers at one of four fixed target addresses, chosen by two strap pins. It keeps the following registers locally:
- the two fixed identification bytes;
- four threshold and line-select settings, which are also exported as configuration outputs.

Every other index is passed to neighbouring blocks. A write to it appears as a one-cycle strobe with index and data. A read of it takes its byte from a read-data input, which is addressed by the current index pointer. This is how live detector results are reached.

Top module: `vdig_i2c_target`

## Requirements
- R1: The 7-bit target address is `{10011, addr_sel[1], addr_sel[0]}`, so the write address byte is 98h, 9Ah, 9Ch or 9Eh and the read address byte is 99h, 9Bh, 9Dh or 9Fh. An address byte that matches neither is not acknowledged, and the block ignores the bus until the next START.
- R2: A START (SDA falls while SCL is high) from any state begins reception of a new address byte. A STOP (SDA rises while SCL is high) returns the block to idle. A transaction cut short by either condition writes nothing.
- R3: A write is START, write address, register index, data byte, STOP. The target acknowledges each of the three bytes by pulling SDA low during the ninth clock, and the addressed register takes the data byte. Bytes are received MSB first and sampled while SCL is high.
- R4: A read is START, write address, index, repeated START, read address, then eight data bits. The target drives these bits MSB first, changing SDA after each SCL fall. It leaves SDA released during the host's NACK clock.
- R5: Index 00h reads the fixed value 46h and index 04h reads the fixed value 87h. Writes to these two indices change nothing and raise no write strobe.
- R6: After reset the local registers hold these values, also visible on the configuration ports: 11h = 20h, 0Fh = 20h, 10h = 06h, 19h = 37h. SDA is released.
- R7: Every accepted data byte to an index other than 00h or 04h raises `wr_stb` for exactly one system clock, with `wr_idx` and `wr_data` holding the index and the byte.
- R8: A read of any index that is neither fixed nor local returns `ext_rd_data`, sampled while `ext_rd_idx` equals that index.
- R9: The target changes its SDA drive only while SCL is low.
- R10: Only one data byte is accepted per write transaction. Further bytes before the STOP are not acknowledged and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_sel | input | 2 | Strap pins choosing one of four target addresses |
| wr_stb | output | 1 | One-cycle write strobe for neighbouring blocks |
| wr_idx | output | 8 | Register index of the current write |
| wr_data | output | 8 | Data byte of the current write |
| ext_rd_idx | output | 8 | Index pointer presented to external read sources |
| ext_rd_data | input | 8 | Read data returned by external sources for `ext_rd_idx` |
| cfg_hthresh | output | 8 | Horizontal luma threshold (index 11h) |
| cfg_vthresh | output | 8 | Vertical luma threshold (index 0Fh) |
| cfg_hline | output | 8 | Line select for horizontal detection (index 10h) |
| cfg_vcol | output | 8 | Column select for vertical detection (index 19h) |

## Verification
A wrong bit counter or a stuck state shows at the ports within one byte time. The next acknowledge either goes missing or lands on a data bit, and a read returns a byte rotated by one or more places. A corrupted index pointer shows on the next read-back or strobe as a wrong value or a wrong `wr_idx`, and a bad address compare shows as an ACK where a NACK is due. Reading the fixed bytes, the external path and the local registers after each write ties every stored value to an observable transfer within one transaction.

// File: rtl/vdig_i2c_pkg.sv
package vdig_i2c_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_INDEX,
    ST_INDEX_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } tgt_state_e;

  localparam logic [7:0] IDX_ID0   = 8'h00;
  localparam logic [7:0] IDX_ID1   = 8'h04;
  localparam logic [7:0] IDX_VTH   = 8'h0F;
  localparam logic [7:0] IDX_HLINE = 8'h10;
  localparam logic [7:0] IDX_HTH   = 8'h11;
  localparam logic [7:0] IDX_VCOL  = 8'h19;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_s,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_pipe[STAGES-1];
      sda_q <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import vdig_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_HI = 5'b10011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [1:0] addr_sel,
  input  logic [7:0] rd_byte,
  output logic       sda_oe,
  output logic [7:0] idx_ptr,
  output logic       wr_en,
  output logic [7:0] wr_data
);

  tgt_state_e state, state_n;
  logic [2:0] cnt, cnt_n;
  logic [7:0] sh, sh_n;
  logic [7:0] tx, tx_n;
  logic       ack_on, ack_n;
  logic       rd_flag, rd_n;
  logic [7:0] idx_n, wd_n;
  logic       wen_n;
  logic [7:0] byte_in;

  assign byte_in = {sh[6:0], sda_s};

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    sh_n    = sh;
    tx_n    = tx;
    ack_n   = ack_on;
    rd_n    = rd_flag;
    idx_n   = idx_ptr;
    wd_n    = wr_data;
    wen_n   = 1'b0;
    if (stop_det) begin
      state_n = ST_IDLE;
      ack_n   = 1'b0;
    end else if (start_det) begin
      state_n = ST_ADDR;
      cnt_n   = 3'd0;
      ack_n   = 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_INDEX, ST_WDATA: begin
          if (scl_rise) begin
            sh_n  = byte_in;
            cnt_n = cnt + 3'd1;
            if (cnt == 3'd7) begin
              cnt_n = 3'd0;
              if (state == ST_ADDR) begin
                if (byte_in[7:1] == {ADDR_HI, addr_sel}) begin
                  state_n = ST_ADDR_ACK;
                  rd_n    = byte_in[0];
                end else begin
                  state_n = ST_IDLE;
                end
              end else if (state == ST_INDEX) begin
                idx_n   = byte_in;
                state_n = ST_INDEX_ACK;
              end else begin
                wen_n   = 1'b1;
                wd_n    = byte_in;
                state_n = ST_WDATA_ACK;
              end
            end
          end
        end
        ST_ADDR_ACK, ST_INDEX_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            if (!ack_on) begin
              ack_n = 1'b1;
            end else begin
              ack_n = 1'b0;
              if (state == ST_ADDR_ACK) begin
                if (rd_flag) begin
                  state_n = ST_RDATA;
                  tx_n    = rd_byte;
                end else begin
                  state_n = ST_INDEX;
                end
              end else if (state == ST_INDEX_ACK) begin
                state_n = ST_WDATA;
              end else begin
                state_n = ST_IDLE;
              end
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt == 3'd7) begin
              cnt_n   = 3'd0;
              state_n = ST_RDATA_ACK;
            end else begin
              cnt_n = cnt + 3'd1;
              tx_n  = {tx[6:0], 1'b1};
            end
          end
        end
        ST_RDATA_ACK: begin
          if (scl_rise) state_n = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= 3'd0;
      sh      <= 8'h00;
      tx      <= 8'hFF;
      ack_on  <= 1'b0;
      rd_flag <= 1'b0;
      idx_ptr <= 8'h00;
      wr_data <= 8'h00;
      wr_en   <= 1'b0;
    end else begin
      state   <= state_n;
      cnt     <= cnt_n;
      sh      <= sh_n;
      tx      <= tx_n;
      ack_on  <= ack_n;
      rd_flag <= rd_n;
      idx_ptr <= idx_n;
      wr_data <= wd_n;
      wr_en   <= wen_n;
    end
  end

  assign sda_oe = ack_on | ((state == ST_RDATA) & ~tx[7]);

  assert_start_to_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (state == ST_ADDR));

  assert_stop_to_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE));

  assert_sda_when_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  assert_single_wr_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

endmodule

// File: rtl/vdig_regfile.sv
module vdig_regfile
  import vdig_i2c_pkg::*;
#(
  parameter logic [7:0] ID0_VAL   = 8'h46,
  parameter logic [7:0] ID1_VAL   = 8'h87,
  parameter logic [7:0] DEF_HTH   = 8'h20,
  parameter logic [7:0] DEF_VTH   = 8'h20,
  parameter logic [7:0] DEF_HLINE = 8'h06,
  parameter logic [7:0] DEF_VCOL  = 8'h37
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_idx,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_idx,
  input  logic [7:0] ext_rd_data,
  output logic [7:0] rd_data,
  output logic       wr_stb,
  output logic [7:0] cfg_hthresh,
  output logic [7:0] cfg_vthresh,
  output logic [7:0] cfg_hline,
  output logic [7:0] cfg_vcol
);

  localparam int NLOC = 4;
  localparam logic [7:0] LOC_IDX [NLOC] = '{IDX_HTH, IDX_VTH, IDX_HLINE, IDX_VCOL};
  localparam logic [7:0] LOC_DEF [NLOC] = '{DEF_HTH, DEF_VTH, DEF_HLINE, DEF_VCOL};

  logic [7:0] loc_q [NLOC];
  logic       fixed_hit;

  assign fixed_hit = (wr_idx == IDX_ID0) || (wr_idx == IDX_ID1);
  assign wr_stb    = wr_en & ~fixed_hit;

  generate
    for (genvar g = 0; g < NLOC; g++) begin : g_loc
      logic hit;
      assign hit = wr_en & (wr_idx == LOC_IDX[g]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) loc_q[g] <= LOC_DEF[g];
        else if (hit) loc_q[g] <= wr_data;
      end
    end
  endgenerate

  always_comb begin
    rd_data = ext_rd_data;
    for (int i = 0; i < NLOC; i++) begin
      if (rd_idx == LOC_IDX[i]) rd_data = loc_q[i];
    end
    if (rd_idx == IDX_ID0) rd_data = ID0_VAL;
    if (rd_idx == IDX_ID1) rd_data = ID1_VAL;
  end

  assign cfg_hthresh = loc_q[0];
  assign cfg_vthresh = loc_q[1];
  assign cfg_hline   = loc_q[2];
  assign cfg_vcol    = loc_q[3];

  assert_fixed_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_idx != IDX_ID0 && wr_idx != IDX_ID1));

  assert_hthresh_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_HTH) |=> (cfg_hthresh == $past(wr_data)));

endmodule

// File: rtl/vdig_i2c_target.sv
module vdig_i2c_target
  import vdig_i2c_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_HI     = 5'b10011,
  parameter logic [7:0] DEF_HTH     = 8'h20,
  parameter logic [7:0] DEF_VTH     = 8'h20,
  parameter logic [7:0] DEF_HLINE   = 8'h06,
  parameter logic [7:0] DEF_VCOL    = 8'h37
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] addr_sel,
  output logic       wr_stb,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic [7:0] ext_rd_idx,
  input  logic [7:0] ext_rd_data,
  output logic [7:0] cfg_hthresh,
  output logic [7:0] cfg_vthresh,
  output logic [7:0] cfg_hline,
  output logic [7:0] cfg_vcol
);

  logic [1:0] rst_pipe;
  logic       rst_s_n;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       wr_en;
  logic [7:0] idx_ptr;
  logic [7:0] rd_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det)
  );

  i2c_target_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
    .clk(clk), .rst_n(rst_s_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .addr_sel(addr_sel), .rd_byte(rd_byte), .sda_oe(sda_oe),
    .idx_ptr(idx_ptr), .wr_en(wr_en), .wr_data(wr_data)
  );

  vdig_regfile #(
    .DEF_HTH(DEF_HTH), .DEF_VTH(DEF_VTH),
    .DEF_HLINE(DEF_HLINE), .DEF_VCOL(DEF_VCOL)
  ) u_regs (
    .clk(clk), .rst_n(rst_s_n), .wr_en(wr_en), .wr_idx(idx_ptr),
    .wr_data(wr_data), .rd_idx(idx_ptr), .ext_rd_data(ext_rd_data),
    .rd_data(rd_byte), .wr_stb(wr_stb),
    .cfg_hthresh(cfg_hthresh), .cfg_vthresh(cfg_vthresh),
    .cfg_hline(cfg_hline), .cfg_vcol(cfg_vcol)
  );

  assign wr_idx     = idx_ptr;
  assign ext_rd_idx = idx_ptr;

endmodule

// File: tb/vdig_i2c_target_tb.sv
module vdig_i2c_target_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_drv = 1'b1;
  logic       sda_drv = 1'b1;
  logic [1:0] addr_sel = 2'b00;
  logic       sda_oe, wr_stb;
  logic [7:0] wr_idx, wr_data, ext_rd_idx, ext_rd_data;
  logic [7:0] cfg_hthresh, cfg_vthresh, cfg_hline, cfg_vcol;
  logic       sda_line;

  int n_checks = 0;
  int n_fail   = 0;
  int r9_viol  = 0;
  logic [15:0] exp_q [$];

  always #4 clk = ~clk;

  assign sda_line    = sda_drv & ~sda_oe;
  assign ext_rd_data = ext_rd_idx ^ 8'hA5;

  vdig_i2c_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .sda_oe(sda_oe), .addr_sel(addr_sel), .wr_stb(wr_stb),
    .wr_idx(wr_idx), .wr_data(wr_data), .ext_rd_idx(ext_rd_idx),
    .ext_rd_data(ext_rd_data), .cfg_hthresh(cfg_hthresh),
    .cfg_vthresh(cfg_vthresh), .cfg_hline(cfg_hline), .cfg_vcol(cfg_vcol)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every write strobe must match the next expected item
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected strobe", {wr_idx, wr_data}, 16'h0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check({wr_idx, wr_data} == e, "R7 strobe index/data", {wr_idx, wr_data}, e);
      end
    end
    if (rst_n && (sda_oe !== oe_prev) && scl_drv) r9_viol++;
    oe_prev = sda_oe;
  end

  task automatic hp();
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; hp();
    scl_drv = 1'b1; hp();
    sda_drv = 1'b0; hp();
    scl_drv = 1'b0; hp();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; hp();
    scl_drv = 1'b1; hp();
    sda_drv = 1'b1; hp();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; hp();
      scl_drv = 1'b1; hp();
      scl_drv = 1'b0;
    end
    sda_drv = 1'b1; hp();
    scl_drv = 1'b1; hp();
    acked = ~sda_line;
    scl_drv = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] v);
    sda_drv = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hp();
      scl_drv = 1'b1; hp();
      v = {v[6:0], sda_line};
      scl_drv = 1'b0;
    end
    hp();
    scl_drv = 1'b1; hp();  // host NACK: SDA must stay released
    check(sda_line == 1'b1, "R4 SDA released on host NACK", {15'h0, sda_line}, 16'h1);
    scl_drv = 1'b0; hp();
  endtask

  function automatic logic [7:0] waddr(input logic [1:0] s);
    return {5'b10011, s, 1'b0};
  endfunction

  task automatic reg_write(input logic [7:0] idx, input logic [7:0] d, input string req);
    bit a0, a1, a2;
    if (idx != 8'h00 && idx != 8'h04) exp_q.push_back({idx, d});
    bus_start();
    send_byte(waddr(addr_sel), a0);
    send_byte(idx, a1);
    send_byte(d, a2);
    bus_stop();
    check(a0 && a1 && a2, req, {13'h0, a0, a1, a2}, 16'h7);
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [7:0] v);
    bit a0, a1, a2;
    bus_start();
    send_byte(waddr(addr_sel), a0);
    send_byte(idx, a1);
    bus_start();
    send_byte(waddr(addr_sel) | 8'h01, a2);
    recv_byte(v);
    bus_stop();
    check(a0 && a1 && a2, "R4 read acks", {13'h0, a0, a1, a2}, 16'h7);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 16'h0, 16'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    bit a, b;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R6 reset state
    check(sda_oe == 1'b0, "R6 SDA released", {15'h0, sda_oe}, 16'h0);
    check(cfg_hthresh == 8'h20, "R6 hthresh default", {8'h0, cfg_hthresh}, 16'h20);
    check(cfg_vthresh == 8'h20, "R6 vthresh default", {8'h0, cfg_vthresh}, 16'h20);
    check(cfg_hline == 8'h06, "R6 hline default", {8'h0, cfg_hline}, 16'h06);
    check(cfg_vcol == 8'h37, "R6 vcol default", {8'h0, cfg_vcol}, 16'h37);
    reg_read(8'h19, v);
    check(v == 8'h37, "R6 read of index 19h", {8'h0, v}, 16'h37);

    // R5 fixed identification bytes
    reg_read(8'h00, v);
    check(v == 8'h46, "R5 id byte 00h", {8'h0, v}, 16'h46);
    reg_read(8'h04, v);
    check(v == 8'h87, "R5 id byte 04h", {8'h0, v}, 16'h87);

    // R3 / R4 write then read back, MSB-first patterns
    reg_write(8'h11, 8'h5A, "R3 write acks 11h");
    check(cfg_hthresh == 8'h5A, "R3 hthresh port", {8'h0, cfg_hthresh}, 16'h5A);
    reg_read(8'h11, v);
    check(v == 8'h5A, "R4 read back 11h", {8'h0, v}, 16'h5A);
    reg_write(8'h0F, 8'h81, "R3 write acks 0Fh");
    reg_read(8'h0F, v);
    check(v == 8'h81, "R4 read back 0Fh", {8'h0, v}, 16'h81);

    // R5 write to fixed byte ignored
    reg_write(8'h00, 8'hFF, "R5 write acks 00h");
    reg_read(8'h00, v);
    check(v == 8'h46, "R5 id unchanged after write", {8'h0, v}, 16'h46);

    // R7 external write strobe, R8 external read path
    reg_write(8'h30, 8'hC3, "R7 write acks 30h");
    reg_read(8'h12, v);
    check(v == 8'hB7, "R8 external read 12h", {8'h0, v}, 16'hB7);

    // R1 foreign address not acknowledged, bus ignored
    bus_start();
    send_byte(8'h9C, a);
    send_byte(8'h11, b);
    bus_stop();
    check(!a && !b, "R1 foreign address NACK", {14'h0, a, b}, 16'h0);
    check(cfg_hthresh == 8'h5A, "R1 no write from foreign address", {8'h0, cfg_hthresh}, 16'h5A);
    addr_sel = 2'b10;
    reg_write(8'h10, 8'h0C, "R1 write at address 9Ch");
    check(cfg_hline == 8'h0C, "R1 hline via 9Ch", {8'h0, cfg_hline}, 16'h0C);
    addr_sel = 2'b11;
    reg_read(8'h10, v);
    check(v == 8'h0C, "R1 read at address 9Fh", {8'h0, v}, 16'h0C);

    // R10 second data byte refused
    bus_start();
    send_byte(waddr(addr_sel), a);
    send_byte(8'h19, a);
    exp_q.push_back({8'h19, 8'h44});
    send_byte(8'h44, a);
    send_byte(8'h99, b);
    bus_stop();
    check(a && !b, "R10 second byte NACK", {14'h0, a, b}, 16'h2);
    check(cfg_vcol == 8'h44, "R10 only first byte written", {8'h0, cfg_vcol}, 16'h44);

    // R2 STOP before data, and START restarting mid-byte
    bus_start();
    send_byte(waddr(addr_sel), a);
    send_byte(8'h11, a);
    bus_stop();
    check(cfg_hthresh == 8'h5A, "R2 stop before data writes nothing", {8'h0, cfg_hthresh}, 16'h5A);
    bus_start();
    for (int i = 0; i < 3; i++) begin
      sda_drv = 1'b1; hp(); scl_drv = 1'b1; hp(); scl_drv = 1'b0;
    end
    reg_write(8'h11, 8'h3C, "R2 restart after aborted byte");
    check(cfg_hthresh == 8'h3C, "R2 write after restart", {8'h0, cfg_hthresh}, 16'h3C);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R7 all strobes seen", 16'(exp_q.size()), 16'h0);
    check(r9_viol == 0, "R9 SDA changes only with SCL low", 16'(r9_viol), 16'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule